// File: doc/BRIEF.md
# Display Refresh DRAM Arbiter

This block shares a single fast-page-mode DRAM command port between two requesters: a display refresh buffer that must be topped up on a fixed schedule, and a drawing engine that uses whatever time is left. One clock cycle equals one column-access (CAS) time unit. A row open (RAS) costs `RAS_CAS` cycles, two by default. Every access moves one 32-bit word. A free-running slot counter divides time into refill periods of `PERIOD_CAS` cycles. The default of 15 corresponds to 32 pixels at 15 ns per pixel with a 32 ns column cycle.

While the display is active and the buffer asks for data, the arbiter starts a refill burst at slot 0 of each period. The burst is one row open followed by `REFILL_WORDS` column accesses. The drawing engine offers bursts over a valid/ready channel, with a start word address and a length. A drawing burst is accepted only when its own row open and all of its words end before the next period boundary. While the display is blanked there is no boundary to respect, so drawing bursts follow one another back to back.

If the display becomes active while a long blanking-time burst is still running, the refill takes the port at the period boundary. The unfinished words of the drawing burst are kept and replayed later under a new row open. Two counters report how many words each requester has received.

Top module: `disp_dram_arbiter`

## Requirements
- R1: While `rst` is high, `dram_ras`, `dram_cas`, `refill_ack` and `draw_done` are 0 and both word counters are 0. The first cycle after `rst` falls is slot 0 of a period.
- R2: If `disp_active` and `refill_req` are both high at the clock edge that opens slot 0, slots 0 and 1 carry RAS at `refill_addr`. Slots 2 to 9 then carry CAS at `refill_addr` and the next seven consecutive word addresses.
- R3: `refill_ack` is high only in the cycle of a refill burst's last CAS, which is slot `RAS_CAS+REFILL_WORDS-1` (slot 9).
- R4: `dram_ras` and `dram_cas` are never high together. Every run of CAS cycles directly follows at least `RAS_CAS` RAS cycles whose address is that of the run's first word.
- R5: An accepted drawing request (`draw_valid && draw_ready` at an edge) produces `draw_len` CAS cycles (1 to `DRAW_MAX`) at consecutive word addresses starting at `draw_addr`. Requests are served in acceptance order. While the display is active, a request is accepted only if `RAS_CAS + draw_len` cycles fit before the next slot 0.
- R6: With the display active, `refill_req` high and a drawing request always offered, each period delivers 8 refill words. It delivers 3 drawing words per period for length 3, 1 for length 1, and 0 for length 4.
- R7: While `disp_active` is low, no refill burst starts. With requests offered continuously, consecutive `draw_done` pulses are exactly `RAS_CAS + draw_len` cycles apart.
- R8: A refill that becomes due during a drawing burst pre-empts it after the last word already issued. While the remaining words wait, `draw_ready` is low. Those words are issued, under a new row open, before any newer request.
- R9: `draw_done` pulses once per accepted request, in the cycle of its final CAS.
- R10: `disp_words` and `draw_words` count the CAS cycles issued for refills and for drawing, and each changes only in a cycle that carries a CAS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CAS time unit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| disp_active | input | 1 | High during the visible part of a line; low during blanking |
| refill_req | input | 1 | Display buffer wants a refill at the next period start |
| refill_addr | input | AW | First word address of the next refill |
| refill_ack | output | 1 | Pulses with the last word of a refill burst |
| draw_valid | input | 1 | Drawing engine offers a burst |
| draw_ready | output | 1 | Arbiter takes the offered burst at this edge |
| draw_addr | input | AW | First word address of the offered burst |
| draw_len | input | LW | Number of words in the offered burst (1 to DRAW_MAX) |
| draw_done | output | 1 | Pulses with the last word of a drawing burst |
| dram_ras | output | 1 | Row-open command this cycle |
| dram_cas | output | 1 | Column access this cycle |
| dram_addr | output | AW | Word address of the current command |
| disp_words | output | CW | Words granted to the display |
| draw_words | output | CW | Words granted to the drawing engine |

## Verification
Drawing lengths of 1, 3 and 4 under continuous display refill are used to find the exact fit boundary after the refill burst. Length 3 fills the five leftover cycles exactly, length 1 leaves a two-cycle hole that cannot hold another burst, and length 4 never fits. A blanking run shows whether bursts are packed back to back without a period boundary. A long burst that is caught by the display turning active separates correct truncation and ordered replay from both dropped words and queue jumping. A long random run that toggles blanking, refill requests, lengths and addresses checks every word address against a scoreboard of accepted requests and refill starts.

// File: rtl/dra_pkg.sv
package dra_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_DISP = 2'd1,
    OWN_DRAW = 2'd2
  } owner_e;

endpackage

// File: rtl/dra_slot_timer.sv
module dra_slot_timer #(
  parameter int PERIOD_CAS = 15,
  localparam int SW = (PERIOD_CAS > 2) ? $clog2(PERIOD_CAS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot,
  output logic [SW-1:0] nslot
);

  localparam logic [SW-1:0] LAST = SW'(PERIOD_CAS - 1);

  // Slot of the command that the next edge will register.
  always_comb begin
    if (slot == LAST) nslot = '0;
    else              nslot = slot + SW'(1);
  end

  // Reset parks on the last slot so the first live cycle is slot 0.
  always_ff @(posedge clk) begin
    if (rst) slot <= LAST;
    else     slot <= nslot;
  end

endmodule

// File: rtl/dra_burst_seq.sv
module dra_burst_seq
  import dra_pkg::*;
#(
  parameter int AW      = 24,
  parameter int LW      = 4,
  parameter int RAS_CAS = 2,
  localparam int RW = $clog2(RAS_CAS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  owner_e        start_own,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  output owner_e        cur_own,
  output logic [LW-1:0] cur_wrem,
  output logic [AW-1:0] cur_waddr,
  output owner_e        cas_own,
  output logic          cmd_ras,
  output logic          cmd_cas,
  output logic [AW-1:0] cmd_addr,
  output logic          last_disp,
  output logic          last_draw
);

  logic [RW-1:0] ras_rem;

  owner_e        e_own, n_own;
  logic [RW-1:0] e_ras, n_ras;
  logic [LW-1:0] e_w,   n_w;
  logic [AW-1:0] e_a,   n_a;
  logic          n_cmd_ras, n_cmd_cas, n_last;
  logic [AW-1:0] n_cmd_addr;

  always_comb begin
    e_own = start ? start_own      : cur_own;
    e_ras = start ? RW'(RAS_CAS)   : ras_rem;
    e_w   = start ? start_len      : cur_wrem;
    e_a   = start ? start_addr     : cur_waddr;

    n_own      = e_own;
    n_ras      = e_ras;
    n_w        = e_w;
    n_a        = e_a;
    n_cmd_ras  = 1'b0;
    n_cmd_cas  = 1'b0;
    n_cmd_addr = cmd_addr;
    n_last     = 1'b0;
    cas_own    = OWN_NONE;

    if (e_own != OWN_NONE) begin
      if (e_ras != '0) begin
        n_cmd_ras  = 1'b1;
        n_cmd_addr = e_a;
        n_ras      = e_ras - RW'(1);
      end else if (e_w != '0) begin
        n_cmd_cas  = 1'b1;
        n_cmd_addr = e_a;
        n_a        = e_a + AW'(1);
        n_w        = e_w - LW'(1);
        n_last     = (e_w == LW'(1));
        cas_own    = e_own;
      end
      if (n_ras == '0 && n_w == '0) n_own = OWN_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_own   <= OWN_NONE;
      ras_rem   <= '0;
      cur_wrem  <= '0;
      cur_waddr <= '0;
      cmd_ras   <= 1'b0;
      cmd_cas   <= 1'b0;
      cmd_addr  <= '0;
      last_disp <= 1'b0;
      last_draw <= 1'b0;
    end else begin
      cur_own   <= n_own;
      ras_rem   <= n_ras;
      cur_wrem  <= n_w;
      cur_waddr <= n_a;
      cmd_ras   <= n_cmd_ras;
      cmd_cas   <= n_cmd_cas;
      cmd_addr  <= n_cmd_addr;
      last_disp <= n_last && (e_own == OWN_DISP);
      last_draw <= n_last && (e_own == OWN_DRAW);
    end
  end

endmodule

// File: rtl/dra_word_counter.sv
module dra_word_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + CW'(1);
  end

endmodule

// File: rtl/disp_dram_arbiter.sv
module disp_dram_arbiter
  import dra_pkg::*;
#(
  parameter int PERIOD_CAS   = 15,
  parameter int RAS_CAS      = 2,
  parameter int REFILL_WORDS = 8,
  parameter int DRAW_MAX     = 8,
  parameter int AW           = 24,
  parameter int CW           = 16,
  localparam int LEN_MAX = (REFILL_WORDS > DRAW_MAX) ? REFILL_WORDS : DRAW_MAX,
  localparam int LW      = $clog2(LEN_MAX + 1),
  localparam int SW      = (PERIOD_CAS > 2) ? $clog2(PERIOD_CAS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          disp_active,
  input  logic          refill_req,
  input  logic [AW-1:0] refill_addr,
  output logic          refill_ack,
  input  logic          draw_valid,
  output logic          draw_ready,
  input  logic [AW-1:0] draw_addr,
  input  logic [LW-1:0] draw_len,
  output logic          draw_done,
  output logic          dram_ras,
  output logic          dram_cas,
  output logic [AW-1:0] dram_addr,
  output logic [CW-1:0] disp_words,
  output logic [CW-1:0] draw_words
);

  localparam int FW = SW + LW + 2;

  logic [SW-1:0] slot, nslot;
  owner_e        cur_own, cas_own, start_own;
  logic [LW-1:0] cur_wrem, start_len;
  logic [AW-1:0] cur_waddr, start_addr;
  logic          start;

  logic          pend_valid;
  logic [AW-1:0] pend_addr;
  logic [LW-1:0] pend_len;

  logic          refill_go, pend_go, draw_go, seq_idle;
  logic          pend_fits, draw_fits;
  logic [FW-1:0] pend_end, draw_end;

  dra_slot_timer #(.PERIOD_CAS(PERIOD_CAS)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .slot  (slot),
    .nslot (nslot)
  );

  // Budget test: a burst starting at nslot must end by the period boundary.
  always_comb begin
    pend_end  = FW'(nslot) + FW'(RAS_CAS) + FW'(pend_len);
    draw_end  = FW'(nslot) + FW'(RAS_CAS) + FW'(draw_len);
    pend_fits = !disp_active || (pend_end <= FW'(PERIOD_CAS));
    draw_fits = !disp_active || (draw_end <= FW'(PERIOD_CAS));
  end

  always_comb begin
    seq_idle   = (cur_own == OWN_NONE);
    refill_go  = (nslot == '0) && disp_active && refill_req;
    pend_go    = !refill_go && seq_idle && pend_valid && pend_fits;
    draw_ready = !refill_go && seq_idle && !pend_valid && draw_fits;
    draw_go    = draw_valid && draw_ready;
    start      = refill_go || pend_go || draw_go;

    if (refill_go) begin
      start_own  = OWN_DISP;
      start_addr = refill_addr;
      start_len  = LW'(REFILL_WORDS);
    end else if (pend_go) begin
      start_own  = OWN_DRAW;
      start_addr = pend_addr;
      start_len  = pend_len;
    end else begin
      start_own  = OWN_DRAW;
      start_addr = draw_addr;
      start_len  = draw_len;
    end
  end

  // Words of a pre-empted drawing burst wait here for a fresh row open.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_len   <= '0;
    end else if (refill_go && cur_own == OWN_DRAW && cur_wrem != '0) begin
      pend_valid <= 1'b1;
      pend_addr  <= cur_waddr;
      pend_len   <= cur_wrem;
    end else if (pend_go) begin
      pend_valid <= 1'b0;
    end
  end

  dra_burst_seq #(
    .AW      (AW),
    .LW      (LW),
    .RAS_CAS (RAS_CAS)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_own  (start_own),
    .start_addr (start_addr),
    .start_len  (start_len),
    .cur_own    (cur_own),
    .cur_wrem   (cur_wrem),
    .cur_waddr  (cur_waddr),
    .cas_own    (cas_own),
    .cmd_ras    (dram_ras),
    .cmd_cas    (dram_cas),
    .cmd_addr   (dram_addr),
    .last_disp  (refill_ack),
    .last_draw  (draw_done)
  );

  dra_word_counter #(.CW(CW)) u_cnt_disp (
    .clk   (clk),
    .rst   (rst),
    .inc   (cas_own == OWN_DISP),
    .count (disp_words)
  );

  dra_word_counter #(.CW(CW)) u_cnt_draw (
    .clk   (clk),
    .rst   (rst),
    .inc   (cas_own == OWN_DRAW),
    .count (draw_words)
  );

endmodule

// File: rtl/dra_checker.sv
module dra_checker #(
  parameter int PERIOD_CAS = 15,
  parameter int CW         = 16,
  localparam int SW = (PERIOD_CAS > 2) ? $clog2(PERIOD_CAS) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          disp_active,
  input logic          refill_req,
  input logic          refill_ack,
  input logic          draw_ready,
  input logic          draw_done,
  input logic          dram_ras,
  input logic          dram_cas,
  input logic [CW-1:0] disp_words,
  input logic [CW-1:0] draw_words,
  input logic          pend_valid,
  input logic [SW-1:0] slot
);

  AST_RAS_CAS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(dram_ras && dram_cas)); // R4

  AST_CAS_AFTER_RAS: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cas) |-> $past(dram_ras)); // R4

  AST_RAS_HELD: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras) |=> dram_ras); // R4

  AST_REFILL_AT_SLOT0: assert property (@(posedge clk) disable iff (rst)
    (slot == '0 && $past(disp_active && refill_req)) |-> dram_ras); // R2

  AST_ACK_ON_CAS: assert property (@(posedge clk) disable iff (rst)
    refill_ack |-> dram_cas); // R3

  AST_DONE_ON_CAS: assert property (@(posedge clk) disable iff (rst)
    draw_done |-> dram_cas); // R9

  AST_PEND_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
    pend_valid |-> !draw_ready); // R8

  AST_DISP_CNT_ON_CAS: assert property (@(posedge clk) disable iff (rst)
    (disp_words != $past(disp_words)) |-> dram_cas); // R10

  AST_DRAW_CNT_ON_CAS: assert property (@(posedge clk) disable iff (rst)
    (draw_words != $past(draw_words)) |-> dram_cas); // R10

endmodule

bind disp_dram_arbiter dra_checker #(
  .PERIOD_CAS (PERIOD_CAS),
  .CW         (CW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .disp_active (disp_active),
  .refill_req  (refill_req),
  .refill_ack  (refill_ack),
  .draw_ready  (draw_ready),
  .draw_done   (draw_done),
  .dram_ras    (dram_ras),
  .dram_cas    (dram_cas),
  .disp_words  (disp_words),
  .draw_words  (draw_words),
  .pend_valid  (pend_valid),
  .slot        (slot)
);

// File: tb/sim_disp_dram_arbiter.sv
module sim_disp_dram_arbiter;

  localparam int P   = 15;
  localparam int RAS = 2;
  localparam int RFW = 8;
  localparam int AW  = 24;
  localparam int CW  = 16;
  localparam int LW  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          disp_active = 1'b0;
  logic          refill_req = 1'b0;
  logic [AW-1:0] refill_addr = '0;
  logic          refill_ack;
  logic          draw_valid = 1'b0;
  logic          draw_ready;
  logic [AW-1:0] draw_addr = '0;
  logic [LW-1:0] draw_len = '0;
  logic          draw_done;
  logic          dram_ras, dram_cas;
  logic [AW-1:0] dram_addr;
  logic [CW-1:0] disp_words, draw_words;

  always #4 clk = ~clk;

  disp_dram_arbiter u0 (.*);

  int n_chk = 0, n_fail = 0;
  int bslot = P - 1;
  int ncyc = 0;
  bit acc, pre_ref;
  logic [AW-1:0] pre_raddr, exp_raddr, last_ras_addr;
  logic [AW-1:0] expq[$];
  logic [AW-1:0] next_daddr = 24'h000100;
  int ras_run = 0;
  bit prev_cas = 0;
  int exp_disp = 0, exp_draw = 0, n_refill = 0, n_ack = 0, n_done = 0, n_acc = 0;
  bit gap_mode = 0;
  int last_done = -1;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] rnd_refill_addr();
    return (AW'(1) << (AW-1)) | (AW'($urandom) & ((AW'(1) << (AW-2)) - 1));
  endfunction

  function automatic logic [AW-1:0] rnd_draw_addr();
    return AW'($urandom) & ((AW'(1) << (AW-2)) - 1);
  endfunction

  task automatic monitor();
    if (dram_cas && !prev_cas)
      chk(ras_run >= RAS && last_ras_addr == dram_addr, "R4", "row open before CAS run",
          longint'(last_ras_addr), longint'(dram_addr));
    if (dram_ras) begin
      ras_run++;
      last_ras_addr = dram_addr;
    end else ras_run = 0;
    prev_cas = dram_cas;

    if (bslot == 0 && pre_ref) begin
      chk(dram_ras && dram_addr == pre_raddr, "R2", "refill row open at slot 0",
          longint'(dram_addr), longint'(pre_raddr));
      n_refill++;
      exp_raddr = pre_raddr;
    end
    if (dram_cas) begin
      if (dram_addr[AW-1]) begin
        chk(dram_addr == exp_raddr, "R2", "refill word address",
            longint'(dram_addr), longint'(exp_raddr));
        exp_raddr = exp_raddr + 1;
        exp_disp++;
      end else begin
        exp_draw++;
        if (expq.size() == 0) chk(0, "R5", "unexpected drawing word", longint'(dram_addr), -1);
        else begin
          logic [AW-1:0] e;
          e = expq.pop_front();
          chk(dram_addr == e, "R5", "drawing word address", longint'(dram_addr), longint'(e));
        end
      end
    end
    if (refill_ack) begin
      n_ack++;
      chk(bslot == RAS + RFW - 1, "R3", "refill_ack slot", bslot, RAS + RFW - 1);
    end
    if (draw_done) begin
      n_done++;
      if (gap_mode && last_done >= 0)
        chk(ncyc - last_done == RAS + 4, "R7", "back-to-back burst spacing",
            ncyc - last_done, RAS + 4);
      last_done = ncyc;
    end
  endtask

  task automatic cyc();
    #1;
    acc = draw_valid && draw_ready;
    pre_ref = disp_active && refill_req;
    pre_raddr = refill_addr;
    if (acc) begin
      n_acc++;
      for (int i = 0; i < int'(draw_len); i++) expq.push_back(draw_addr + AW'(i));
    end
    @(posedge clk);
    bslot = (bslot + 1) % P;
    ncyc++;
    @(negedge clk);
    monitor();
  endtask

  // Keep a request of the given length on offer; change it only after acceptance.
  task automatic feed(input int len);
    if (!draw_valid || acc) begin
      draw_valid = 1'b1;
      draw_addr  = next_daddr;
      draw_len   = LW'(len);
      next_daddr = next_daddr + 24'h40;
    end
  endtask

  task automatic run_feed(input int n, input int len);
    for (int i = 0; i < n; i++) begin
      feed(len);
      cyc();
    end
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      if (acc) draw_valid = 1'b0;
      cyc();
    end
    draw_valid = 1'b0;
  endtask

  task automatic bw_phase(input int len, input int exp_per);
    int d0, w0;
    run_feed(3 * P, len);
    while (bslot != P - 1) run_feed(1, len);
    d0 = disp_words;
    w0 = draw_words;
    run_feed(10 * P, len);
    chk(int'(disp_words) - d0 == 10 * RFW, "R6", "refill words in 10 periods",
        int'(disp_words) - d0, 10 * RFW);
    chk(int'(draw_words) - w0 == 10 * exp_per, "R6", "drawing words in 10 periods",
        int'(draw_words) - w0, 10 * exp_per);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(150000 * 8);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", ncyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int w0, d0, dn0;
    void'($urandom(32'h5eed1234));
    refill_addr = 24'h800000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!dram_ras && !dram_cas, "R1", "no command in reset", {dram_ras, dram_cas}, 0);
    chk(disp_words == 0 && draw_words == 0, "R1", "counters cleared", disp_words + draw_words, 0);
    chk(!refill_ack && !draw_done, "R1", "pulses low in reset", {refill_ack, draw_done}, 0);

    disp_active = 1'b1;
    refill_req  = 1'b1;
    rst = 1'b0;
    bslot = P - 1;
    cyc();
    chk(bslot == 0 && dram_ras && dram_addr == 24'h800000, "R1", "first live cycle is slot 0 refill",
        dram_ras, 1);

    // R6 fit boundary under continuous refill
    bw_phase(3, 3);
    bw_phase(1, 1);
    bw_phase(4, 0);

    // R7 blanking: no refill, bursts packed back to back
    disp_active = 1'b0;
    d0 = disp_words;
    run_feed(2 * P, 4);
    gap_mode = 1;
    last_done = -1;
    run_feed(8 * (RAS + 4), 4);
    gap_mode = 0;
    chk(disp_words == CW'(d0), "R7", "no refill words while blanked", disp_words, d0);
    drain(20);
    chk(expq.size() == 0, "R5", "drawing queue empty after drain", expq.size(), 0);

    // R8 truncation and replay
    while (bslot != 11) cyc();
    draw_valid = 1'b1;
    draw_addr  = 24'h00A000;
    draw_len   = 4'd8;
    w0 = draw_words;
    dn0 = n_done;
    cyc();
    chk(acc, "R8", "long burst accepted while blanked", acc, 1);
    draw_valid = 1'b0;
    disp_active = 1'b1;
    while (bslot != 9) cyc();
    draw_valid = 1'b1;
    draw_addr  = 24'h00B000;
    draw_len   = 4'd1;
    cyc();
    chk(!acc, "R8", "new request held off while words wait", acc, 0);
    while (bslot != P - 1) cyc();
    chk(int'(draw_words) - w0 == 1, "R8", "only one word before pre-emption",
        int'(draw_words) - w0, 1);
    disp_active = 1'b0;
    drain(30);
    chk(int'(draw_words) - w0 == 9, "R8", "all words delivered after replay",
        int'(draw_words) - w0, 9);
    chk(n_done - dn0 == 2, "R9", "one done per request", n_done - dn0, 2);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(63) == 0) disp_active = ~disp_active;
      refill_req  = ($urandom_range(7) != 0);
      refill_addr = rnd_refill_addr();
      if (acc) draw_valid = 1'b0;
      if (!draw_valid && $urandom_range(3) == 0) begin
        draw_valid = 1'b1;
        draw_addr  = rnd_draw_addr();
        draw_len   = LW'($urandom_range(8, 1));
      end
      cyc();
    end
    disp_active = 1'b0;
    drain(60);

    chk(expq.size() == 0, "R5", "all accepted words issued", expq.size(), 0);
    chk(n_done == n_acc, "R9", "done pulses equal accepts", n_done, n_acc);
    chk(n_ack == n_refill, "R3", "ack per refill burst", n_ack, n_refill);
    chk(int'(disp_words) == (exp_disp % (1 << CW)), "R10", "display word counter",
        disp_words, exp_disp);
    chk(int'(draw_words) == (exp_draw % (1 << CW)), "R10", "drawing word counter",
        draw_words, exp_draw);

    finished = 1;
    summary();
    $finish;
  end

endmodule